// File: doc/BRIEF.md
# Multi-Locality Access Ownership Arbiter

This block decides which of several software privilege ports, called localities, may use a shared security coprocessor. Only one locality can own the coprocessor at a time. Each locality has an access-control byte. Software reaches these bytes through a single-cycle write port and a combinational read port, and every access carries a locality index. The block drives the current owner on its outputs. Command transport, interrupts and bus framing belong to the blocks around it.

A locality asks for the coprocessor by writing its request bit. The owner gives the coprocessor back by writing its active bit. A higher-numbered locality can take ownership from a lower-numbered owner by writing its seize bit. When that happens, the displaced locality keeps a sticky seized flag. Every locality can also see whether some other locality is waiting.

Access byte bit positions: 7 valid, 5 active, 4 seized, 3 seize, 2 pending, 1 request, 0 no trusted OS established. Bits 6 and 3 read as 0.

Top module: `loc_access_arbiter`

## Requirements
- R1: After reset there is no owner, so `owner_vld` is 0. Every in-range locality reads its byte as 0x80 with bit 0 equal to `tos_absent`.
- R2: For an in-range `rd_loc`, bit 7 of `rd_data` reads 1. An out-of-range `rd_loc` (value of `NUM_LOC` or more) reads 0x00.
- R3: With no owner, a write of 1 to bit 1 grants that locality at the same clock edge. Bit 5 then reads 1 only for the owner.
- R4: With an owner present, a write of 1 to bit 1 from another locality sets that locality's bit 1. Bit 2 then reads 1 for every other locality.
- R5: The owner writing 1 to bit 5 leaves the block with no owner after that edge. At the following edge, the highest-numbered locality with bit 1 set is granted and its bit 1 clears.
- R6: A write of 1 to bit 3 takes effect when there is no owner or the owner is numbered below the writer. The writer then becomes owner at that edge and its bit 1 clears. A displaced owner gets bit 4 set.
- R7: A seize write from a locality numbered at or below the current owner changes nothing.
- R8: A set bit 4 stays set until that locality writes 1 to bit 4 or is granted ownership again.
- R9: Bit 0 of every in-range byte follows the `tos_absent` input.
- R10: Writes with `wr_loc` of `NUM_LOC` or more are ignored. A write of bit 5 from a locality that is not the owner is also ignored.
- R11: `owner_loc` gives the owning locality whenever `owner_vld` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_loc | input | LOC_W | Locality index of the write |
| wr_data | input | 8 | Byte written to the access register |
| rd_loc | input | LOC_W | Locality index of the read |
| rd_data | output | 8 | Access byte of locality `rd_loc` |
| tos_absent | input | 1 | High while no trusted OS is established |
| owner_vld | output | 1 | A locality owns the coprocessor |
| owner_loc | output | LOC_W | Index of the owning locality |

## Verification
Two functions can act in the same cycle: arbitration of pending requests while the coprocessor is free, and a new write arriving on that cycle. The bench makes them meet in two ways. In one, a relinquish is followed by an idle cycle while several requests are pending. In the other, a seize is written while a lower-numbered locality's request is still pending. The bench judges the outcome by the owner outputs after each edge and by each locality's request, pending and seized bits read back afterwards.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
   localparam int BYTE_W      = 8;
   localparam int B_VALID     = 7;
   localparam int B_ACTIVE    = 5;
   localparam int B_SEIZED    = 4;
   localparam int B_SEIZE     = 3;
   localparam int B_PENDING   = 2;
   localparam int B_REQ       = 1;
   localparam int B_TOS_ABS   = 0;

   typedef logic [BYTE_W-1:0] acc_byte_t;
endpackage

// File: rtl/loc_prio_pick.sv
module loc_prio_pick #(
   parameter int N = 5,
   parameter int W = 3
) (
   input  logic [N-1:0] vec,
   output logic         found,
   output logic [W-1:0] idx
);
   // Highest set index wins; walk upward so the last hit overrides.
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = 0; i < N; i++) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = W'(i);
         end
      end
   end
endmodule

// File: rtl/loc_own_ctrl.sv
module loc_own_ctrl
   import loc_arb_pkg::*;
#(
   parameter int N = 5,
   parameter int W = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [W-1:0]  wr_loc,
   input  acc_byte_t     wr_data,
   output logic          owner_vld,
   output logic [W-1:0]  owner_idx,
   output logic [N-1:0]  req_q,
   output logic [N-1:0]  seized_q
);
   logic          vld_q, vld_n;
   logic [W-1:0]  idx_q, idx_n;
   logic [N-1:0]  req_n, seized_n, wr_mask, own_mask, pick_mask, cand;
   logic          wr_hit, is_owner, do_relinq, do_seize, do_req;
   logic          pick_found;
   logic [W-1:0]  pick_idx;
   logic          unused_bits;

   assign unused_bits = ^{wr_data[7:6], wr_data[B_PENDING], wr_data[B_TOS_ABS]};

   assign wr_hit    = wr_en && (32'(wr_loc) < N);
   assign wr_mask   = wr_hit ? (N'(1) << wr_loc) : '0;
   assign own_mask  = vld_q ? (N'(1) << idx_q) : '0;
   assign is_owner  = vld_q && (idx_q == wr_loc);
   assign do_relinq = wr_hit && wr_data[B_ACTIVE] && is_owner;
   assign do_seize  = wr_hit && wr_data[B_SEIZE] && (!vld_q || idx_q < wr_loc);
   assign do_req    = wr_hit && wr_data[B_REQ] && !is_owner && !do_seize;
   assign cand      = req_q | (do_req ? wr_mask : '0);

   loc_prio_pick #(.N(N), .W(W)) u_pick (
      .vec   (cand),
      .found (pick_found),
      .idx   (pick_idx)
   );

   assign pick_mask = N'(1) << pick_idx;

   always_comb begin
      req_n    = req_q;
      seized_n = seized_q;
      vld_n    = vld_q;
      idx_n    = idx_q;
      if (wr_hit && wr_data[B_SEIZED]) seized_n = seized_n & ~wr_mask;
      if (do_relinq) begin
         vld_n = 1'b0;
      end else if (do_seize) begin
         seized_n = (seized_n | own_mask) & ~wr_mask;
         req_n    = req_n & ~wr_mask;
         vld_n    = 1'b1;
         idx_n    = wr_loc;
      end else begin
         req_n = cand;
         if (!vld_q && pick_found) begin
            vld_n    = 1'b1;
            idx_n    = pick_idx;
            req_n    = req_n & ~pick_mask;
            seized_n = seized_n & ~pick_mask;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q    <= 1'b0;
         idx_q    <= '0;
         req_q    <= '0;
         seized_q <= '0;
      end else begin
         vld_q    <= vld_n;
         idx_q    <= idx_n;
         req_q    <= req_n;
         seized_q <= seized_n;
      end
   end

   assign owner_vld = vld_q;
   assign owner_idx = idx_q;

   assert_owner_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
      owner_vld |-> (32'(owner_idx) < N));

   assert_relinquish_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && owner_vld && wr_loc == owner_idx && wr_data[B_ACTIVE]) |=> !owner_vld);

   assert_regrant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!owner_vld && (|req_q) && !wr_en) |=> owner_vld);

   assert_seize_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (32'(wr_loc) < N) && wr_data[B_SEIZE] && (!owner_vld || owner_idx < wr_loc))
      |=> (owner_vld && owner_idx == $past(wr_loc)));

   assert_seize_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && owner_vld && wr_data[B_SEIZE] && !wr_data[B_ACTIVE] && wr_loc <= owner_idx)
      |=> (owner_vld && $stable(owner_idx)));

   for (genvar g = 0; g < N; g++) begin : g_seized_chk
      assert_seized_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(seized_q[g]) |-> $past(vld_q && idx_q == W'(g)));
   end
endmodule

// File: rtl/loc_status_mux.sv
module loc_status_mux
   import loc_arb_pkg::*;
#(
   parameter int N = 5,
   parameter int W = 3
) (
   input  logic [W-1:0] rd_loc,
   input  logic         owner_vld,
   input  logic [W-1:0] owner_idx,
   input  logic [N-1:0] req,
   input  logic [N-1:0] seized,
   input  logic         tos_absent,
   output acc_byte_t    rd_data
);
   acc_byte_t loc_byte [N];

   for (genvar g = 0; g < N; g++) begin : g_byte
      localparam logic [N-1:0] OTHERS = ~(N'(1) << g);
      always_comb begin
         loc_byte[g]            = '0;
         loc_byte[g][B_VALID]   = 1'b1;
         loc_byte[g][B_ACTIVE]  = owner_vld && (owner_idx == W'(g));
         loc_byte[g][B_SEIZED]  = seized[g];
         loc_byte[g][B_PENDING] = |(req & OTHERS);
         loc_byte[g][B_REQ]     = req[g];
         loc_byte[g][B_TOS_ABS] = tos_absent;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < N; i++) begin
         if (rd_loc == W'(i)) rd_data = loc_byte[i];
      end
   end
endmodule

// File: rtl/loc_access_arbiter.sv
module loc_access_arbiter
   import loc_arb_pkg::*;
#(
   parameter int NUM_LOC = 5,
   parameter int LOC_W   = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [LOC_W-1:0] wr_loc,
   input  logic [7:0]       wr_data,
   input  logic [LOC_W-1:0] rd_loc,
   output logic [7:0]       rd_data,
   input  logic             tos_absent,
   output logic             owner_vld,
   output logic [LOC_W-1:0] owner_loc
);
   if (NUM_LOC < 2 || NUM_LOC > 16) begin : g_bad_count
      $error("loc_access_arbiter: NUM_LOC must lie in 2..16");
   end
   if ((1 << LOC_W) < NUM_LOC) begin : g_bad_width
      $error("loc_access_arbiter: LOC_W too narrow for NUM_LOC");
   end

   logic [NUM_LOC-1:0] req_q, seized_q;
   logic [LOC_W-1:0]   own_idx;
   logic               own_vld;

   loc_own_ctrl #(.N(NUM_LOC), .W(LOC_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_loc    (wr_loc),
      .wr_data   (wr_data),
      .owner_vld (own_vld),
      .owner_idx (own_idx),
      .req_q     (req_q),
      .seized_q  (seized_q)
   );

   loc_status_mux #(.N(NUM_LOC), .W(LOC_W)) u_rd (
      .rd_loc     (rd_loc),
      .owner_vld  (own_vld),
      .owner_idx  (own_idx),
      .req        (req_q),
      .seized     (seized_q),
      .tos_absent (tos_absent),
      .rd_data    (rd_data)
   );

   assign owner_vld = own_vld;
   assign owner_loc = own_idx;

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> !owner_vld);

   assert_tos_mirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(rd_loc) < NUM_LOC) |-> (rd_data[0] == tos_absent && rd_data[7]));
endmodule

// File: tb/test_loc_access_arbiter.sv
module test_loc_access_arbiter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_loc = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_loc = '0;
   logic [7:0] rd_data;
   logic       tos_absent = 1'b1;
   logic       owner_vld;
   logic [2:0] owner_loc;

   int n_run = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   loc_access_arbiter #(.NUM_LOC(5)) i_loc_access_arbiter (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_loc(wr_loc),
      .wr_data(wr_data), .rd_loc(rd_loc), .rd_data(rd_data),
      .tos_absent(tos_absent), .owner_vld(owner_vld), .owner_loc(owner_loc)
   );

   // {wr_en, wr_loc, wr_data, exp_vld, exp_owner}
   localparam logic [15:0] VEC [12] = '{
      {1'b1, 3'd1, 8'h02, 1'b1, 3'd1},  // R3 free -> loc1 granted
      {1'b1, 3'd0, 8'h02, 1'b1, 3'd1},  // R4 loc0 queued
      {1'b1, 3'd3, 8'h02, 1'b1, 3'd1},  // R4 loc3 queued
      {1'b1, 3'd1, 8'h20, 1'b0, 3'd0},  // R5 release
      {1'b0, 3'd0, 8'h00, 1'b1, 3'd3},  // R5 highest requester wins
      {1'b1, 3'd4, 8'h08, 1'b1, 3'd4},  // R6 seize over loc3
      {1'b1, 3'd2, 8'h08, 1'b1, 3'd4},  // R7 lower seize blocked
      {1'b1, 3'd4, 8'h20, 1'b0, 3'd0},  // R5 release
      {1'b0, 3'd0, 8'h00, 1'b1, 3'd0},  // R5 loc0 still waiting
      {1'b1, 3'd2, 8'h02, 1'b1, 3'd0},  // R4 loc2 queued
      {1'b1, 3'd6, 8'h28, 1'b1, 3'd0},  // R10 out-of-range write
      {1'b1, 3'd2, 8'h20, 1'b1, 3'd0}   // R10 non-owner active write
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] loc, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_loc = loc; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle();
      @(negedge clk);
      @(negedge clk);
   endtask

   function automatic logic [7:0] own();
      return {4'h0, owner_vld, owner_vld ? owner_loc : 3'd0};
   endfunction

   task automatic rd(input string tag, input logic [2:0] loc, input logic [7:0] exp);
      rd_loc = loc;
      #1;
      check(tag, rd_data, exp);
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 no owner after reset", own(), 8'h00);
      rd("R1 reset byte loc0", 3'd0, 8'h81);
      rd("R1 reset byte loc4", 3'd4, 8'h81);

      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         wr_en = VEC[k][15]; wr_loc = VEC[k][14:12]; wr_data = VEC[k][11:4];
         @(negedge clk);
         wr_en = 1'b0;
         check($sformatf("R11 table step %0d owner", k), own(), {4'h0, VEC[k][3:0]});
      end

      // state: owner 0, loc2 requesting, loc3 seized
      rd("R3 owner byte active+pending", 3'd0, 8'hA5);
      rd("R4 requester byte", 3'd2, 8'h83);
      rd("R8 seized sticky loc3", 3'd3, 8'h95);
      rd("R2 out-of-range read", 3'd6, 8'h00);
      rd("R2 valid bit loc1", 3'd1, 8'h85);
      tos_absent = 1'b0;
      rd("R9 tos input low", 3'd2, 8'h82);

      wr(3'd3, 8'h10);
      rd("R8 seized cleared by write", 3'd3, 8'h84);

      wr(3'd3, 8'h08);
      check("R6 seize while loc2 pending", own(), 8'h0B);
      rd("R6 displaced loc0 seized", 3'd0, 8'h94);
      rd("R6 loc2 request kept", 3'd2, 8'h82);

      wr(3'd3, 8'h20);
      check("R5 release", own(), 8'h00);
      idle();
      check("R5 regrant loc2", own(), 8'h0A);
      rd("R5 request cleared on grant", 3'd2, 8'hA0);

      wr(3'd0, 8'h02);
      wr(3'd2, 8'h20);
      idle();
      check("R8 loc0 regains", own(), 8'h08);
      rd("R8 regain clears seized", 3'd0, 8'hA0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule